// File: doc/BRIEF.md
# Dynamic Branch Direction and Target Predictor

This block sits in the fetch stage. Each cycle it takes the fetch PC and returns a taken/not-taken prediction and the address to fetch next. A direct-mapped table of 2-bit hysteresis state machines sets the direction. The table is indexed by the PC bits just above the word offset and has no tag. A parallel target buffer caches one branch target per entry. Fetch should send the prediction bit and the index along with the instruction. Decode can then compare the prediction with the real outcome once it knows the instruction is a branch.

Decode sends back one update per resolved branch. The update carries the index, the actual direction, the actual target and a flag that marks a mispredict. The update is registered and written one cycle later. Flushing wrong-path instructions and redirecting the PC are handled by the pipeline controller, not by this block.

Each entry's state machine has four named states: strong-not-taken (00), weak-not-taken (01), weak-taken (10) and strong-taken (11). The transitions are:
- hold at a strong state on a matching outcome;
- strong to weak of the same direction on a mismatch;
- weak to strong of the same direction on a match;
- weak to weak of the opposite direction on a mismatch.

Top module: `bp_predictor`

## Requirements
- R1: After reset every entry is in weak-not-taken (01) and its target is invalid. Every fetch PC then gives pred_taken = 0 and pred_next_pc = fetch_pc + 4.
- R2: The entry index is fetch_pc[IDX_W+1:2] and is also output on pred_idx. There is no tag, so PCs that differ by a multiple of 4·2^IDX_W share one entry. An entry with a different index is not affected by an update.
- R3: State encoding is 00 strong-not-taken, 01 weak-not-taken, 10 weak-taken and 11 strong-taken. Bit 1 gives the predicted direction.
- R4: From a strong state, a mismatching outcome moves the entry to the weak state of the same direction. A matching outcome leaves it where it is.
- R5: From a weak state, a mismatching outcome moves the entry to the weak state of the opposite direction. A matching outcome moves it to the strong state of its own direction.
- R6: pred_taken is high only when the state predicts taken and the entry's target is valid. In that case pred_next_pc is the cached target; otherwise it is fetch_pc + 4.
- R7: An update with upd_taken = 1 writes upd_target into the target buffer when upd_mispredict = 1 or the cached target is invalid. Not-taken updates, and correctly predicted taken updates that hit a valid target, leave the cached target unchanged.
- R8: An update presented while upd_valid is high is written at the second rising edge. A read of that index in the cycle between the two edges returns the old state and target.
- R9: While upd_valid is low, no state or target changes, whatever the other update inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | PC being fetched |
| pred_taken | output | 1 | Predicted taken |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| pred_idx | output | IDX_W | Table index, to travel with the instruction |
| upd_valid | input | 1 | Decode resolved a branch this cycle |
| upd_idx | input | IDX_W | Index of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | PC_W | Actual target address |
| upd_mispredict | input | 1 | Fetch prediction was wrong |

## Verification
A table of updates drives one entry through every state of the state machine. This shows that a strong state absorbs a single mismatch while a weak state flips direction. The same table changes the offered target with the mispredict flag both set and clear, which tells a target refresh apart from a retained target. Directed checks then fetch:
- an aliasing PC, which must share the entry;
- a neighbouring index, which must stay untouched;
- the index in the cycle between the two update edges, where the old value must still be read.
A last check holds decoy update inputs with upd_valid low and confirms that nothing changes.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        BP_NT_STRONG = 2'b00,
        BP_NT_WEAK   = 2'b01,
        BP_TK_WEAK   = 2'b10,
        BP_TK_STRONG = 2'b11
    } bp_state_e;

    localparam bp_state_e BP_INIT_STATE = BP_NT_WEAK;

endpackage

// File: rtl/bp_state_next.sv
module bp_state_next
    import bp_pkg::*;
(
    input  bp_state_e cur_state,
    input  logic      outcome_taken,
    output bp_state_e nxt_state
);

    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            BP_NT_STRONG: nxt_state = outcome_taken ? BP_NT_WEAK   : BP_NT_STRONG;
            BP_NT_WEAK:   nxt_state = outcome_taken ? BP_TK_WEAK   : BP_NT_STRONG;
            BP_TK_WEAK:   nxt_state = outcome_taken ? BP_TK_STRONG : BP_NT_WEAK;
            BP_TK_STRONG: nxt_state = outcome_taken ? BP_TK_STRONG : BP_TK_WEAK;
            default:      nxt_state = BP_INIT_STATE;
        endcase
    end

endmodule

// File: rtl/bp_pattern_table.sv
module bp_pattern_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output bp_state_e        rd_state,
    input  logic [IDX_W-1:0] chk_idx,
    output bp_state_e        chk_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  bp_state_e        wr_state
);

    localparam int DEPTH = 1 << IDX_W;

    logic [1:0]       state_mem [DEPTH];
    logic [DEPTH-1:0] written;

    // Entries never written read as the initial state; one vector reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written <= '0;
        end else if (wr_en) begin
            written[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            state_mem[wr_idx] <= wr_state;
        end
    end

    assign rd_state  = written[rd_idx]  ? bp_state_e'(state_mem[rd_idx])  : BP_INIT_STATE;
    assign chk_state = written[chk_idx] ? bp_state_e'(state_mem[chk_idx]) : BP_INIT_STATE;

endmodule

// File: rtl/bp_target_buffer.sv
module bp_target_buffer #(
    parameter int IDX_W = 12,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic [IDX_W-1:0] chk_idx,
    output logic             chk_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PC_W-1:0]  wr_target
);

    localparam int DEPTH = 1 << IDX_W;

    logic [PC_W-1:0]  tgt_mem [DEPTH];
    logic [DEPTH-1:0] tgt_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_valid <= '0;
        end else if (wr_en) begin
            tgt_valid[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tgt_mem[wr_idx] <= wr_target;
        end
    end

    assign rd_hit    = tgt_valid[rd_idx];
    assign rd_target = tgt_mem[rd_idx];
    assign chk_hit   = tgt_valid[chk_idx];

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
    import bp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             pred_taken,
    output logic [PC_W-1:0]  pred_next_pc,
    output logic [IDX_W-1:0] pred_idx,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken,
    input  logic [PC_W-1:0]  upd_target,
    input  logic             upd_mispredict
);

    localparam int          OFS_W   = 2;
    localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(1 << OFS_W);

    logic [IDX_W-1:0] fetch_idx;
    bp_state_e        rd_state;
    logic             rd_hit;
    logic [PC_W-1:0]  rd_target;

    // Registered update stage
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_taken;
    logic             wr_mispredict;
    logic [PC_W-1:0]  wr_target;

    bp_state_e        wr_old;
    bp_state_e        wr_new;
    logic             wr_tgt_hit;
    logic             tgt_wr_en;

    assign fetch_idx = fetch_pc[IDX_W+OFS_W-1:OFS_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en <= 1'b0;
        end else begin
            wr_en <= upd_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_valid) begin
            wr_idx        <= upd_idx;
            wr_taken      <= upd_taken;
            wr_mispredict <= upd_mispredict;
            wr_target     <= upd_target;
        end
    end

    bp_pattern_table #(.IDX_W(IDX_W)) i_pht (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (fetch_idx),
        .rd_state  (rd_state),
        .chk_idx   (wr_idx),
        .chk_state (wr_old),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_state  (wr_new)
    );

    bp_state_next i_next (
        .cur_state     (wr_old),
        .outcome_taken (wr_taken),
        .nxt_state     (wr_new)
    );

    assign tgt_wr_en = wr_en && wr_taken && (wr_mispredict || !wr_tgt_hit);

    bp_target_buffer #(.IDX_W(IDX_W), .PC_W(PC_W)) i_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (fetch_idx),
        .rd_hit    (rd_hit),
        .rd_target (rd_target),
        .chk_idx   (wr_idx),
        .chk_hit   (wr_tgt_hit),
        .wr_en     (tgt_wr_en),
        .wr_idx    (wr_idx),
        .wr_target (wr_target)
    );

    always_comb begin
        pred_taken   = rd_state[1] && rd_hit;
        pred_next_pc = pred_taken ? rd_target : fetch_pc + SEQ_STEP;
        pred_idx     = fetch_idx;
    end

endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  fetch_pc,
    input logic             pred_taken,
    input logic [PC_W-1:0]  pred_next_pc,
    input logic             upd_valid,
    input logic [IDX_W-1:0] upd_idx,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [1:0]       wr_old,
    input logic [1:0]       wr_new,
    input logic             wr_taken
);

    assert_update_pipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (wr_en && wr_idx == $past(upd_idx)));

    assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> !wr_en);

    assert_strong_tk_soft_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_old == 2'b11 && !wr_taken) |-> wr_new == 2'b10);

    assert_strong_nt_soft_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_old == 2'b00 && wr_taken) |-> wr_new == 2'b01);

    assert_weak_nt_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_old == 2'b01 && wr_taken) |-> wr_new == 2'b10);

    assert_weak_tk_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_old == 2'b10 && !wr_taken) |-> wr_new == 2'b01);

    assert_seq_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(4));

endmodule

bind bp_predictor bp_predictor_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_taken   (pred_taken),
    .pred_next_pc (pred_next_pc),
    .upd_valid    (upd_valid),
    .upd_idx      (upd_idx),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_old       (wr_old),
    .wr_new       (wr_new),
    .wr_taken     (wr_taken)
);

// File: tb/test_bp_predictor.sv
`timescale 1ns/1ps
module test_bp_predictor;

    localparam int PC_W  = 32;
    localparam int IDX_W = 12;
    localparam logic [31:0] PC_A   = 32'h0000_0100;
    localparam logic [31:0] PC_ALI = 32'h0000_4100;  // same index as PC_A
    localparam logic [31:0] PC_C   = 32'h0000_0104;
    localparam logic [IDX_W-1:0] IDX_A = 12'h040;
    localparam logic [IDX_W-1:0] IDX_C = 12'h041;
    localparam int NVEC = 11;

    // {taken, mispredict, target, expected pred_taken, expected next pc}
    localparam logic [66:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 32'h800, 1'b1, 32'h800},   // 01 -> 10, target fill   (R5 R7)
        {1'b1, 1'b0, 32'h800, 1'b1, 32'h800},   // 10 -> 11                (R5)
        {1'b0, 1'b1, 32'h800, 1'b1, 32'h800},   // 11 -> 10                (R4)
        {1'b1, 1'b0, 32'h800, 1'b1, 32'h800},   // 10 -> 11                (R5)
        {1'b0, 1'b1, 32'h800, 1'b1, 32'h800},   // 11 -> 10                (R4)
        {1'b0, 1'b1, 32'h800, 1'b0, 32'h104},   // 10 -> 01                (R5)
        {1'b0, 1'b0, 32'h800, 1'b0, 32'h104},   // 01 -> 00                (R5)
        {1'b0, 1'b0, 32'h800, 1'b0, 32'h104},   // 00 stays                (R4)
        {1'b1, 1'b1, 32'h900, 1'b0, 32'h104},   // 00 -> 01, target refresh (R4 R7)
        {1'b1, 1'b1, 32'h900, 1'b1, 32'h900},   // 01 -> 10                (R5 R7)
        {1'b1, 1'b0, 32'hA00, 1'b1, 32'h900}    // 10 -> 11, target kept   (R7)
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  fetch_pc = PC_A;
    logic             pred_taken;
    logic [PC_W-1:0]  pred_next_pc;
    logic [IDX_W-1:0] pred_idx;
    logic             upd_valid = 1'b0;
    logic [IDX_W-1:0] upd_idx = '0;
    logic             upd_taken = 1'b0;
    logic [PC_W-1:0]  upd_target = '0;
    logic             upd_mispredict = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bp_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) i_bp_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_next_pc(pred_next_pc), .pred_idx(pred_idx),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_mispredict(upd_mispredict)
    );

    task automatic check_pred(input string req, input logic exp_t, input logic [31:0] exp_pc);
        n_checks++;
        if (pred_taken !== exp_t || pred_next_pc !== exp_pc) begin
            n_fail++;
            $display("FAIL %s: pc=%h got taken=%b next=%h expected taken=%b next=%h",
                     req, fetch_pc, pred_taken, pred_next_pc, exp_t, exp_pc);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Presents one update for a cycle; returns at the negedge after the write edge.
    task automatic send_update(input logic [IDX_W-1:0] idx, input logic tk,
                               input logic mis, input logic [31:0] tgt);
        @(negedge clk);
        upd_valid = 1'b1; upd_idx = idx; upd_taken = tk;
        upd_mispredict = mis; upd_target = tgt;
        @(negedge clk);
        upd_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(100000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3: reset state weak-not-taken, target invalid
        fetch_pc = PC_A; #1;
        check_pred("R1", 1'b0, PC_A + 4);
        fetch_pc = 32'h0000_3FFC; #1;
        check_pred("R1", 1'b0, 32'h0000_4000);
        n_checks++;
        if (pred_idx !== 12'hFFF) begin
            n_fail++;
            $display("FAIL R2: got idx=%h expected idx=%h", pred_idx, 12'hFFF);
        end
        fetch_pc = PC_A;

        // R3 R4 R5 R6 R7: walk the state machine on one entry
        for (int v = 0; v < NVEC; v++) begin
            send_update(IDX_A, VEC[v][66], VEC[v][65], VEC[v][64:33]);
            check_pred($sformatf("R3/R4/R5/R6/R7 vec %0d", v), VEC[v][32], VEC[v][31:0]);
        end

        // R2: aliasing PC shares the entry, neighbour untouched
        fetch_pc = PC_ALI; #1;
        check_pred("R2 alias", 1'b1, 32'h900);
        fetch_pc = PC_C; #1;
        check_pred("R2 neighbour", 1'b0, PC_C + 4);

        // R8: old value visible between presentation and write
        fetch_pc = PC_C;
        @(negedge clk);
        upd_valid = 1'b1; upd_idx = IDX_C; upd_taken = 1'b1;
        upd_mispredict = 1'b1; upd_target = 32'h300;
        @(negedge clk);
        upd_valid = 1'b0;
        #1 check_pred("R8 old value", 1'b0, PC_C + 4);
        @(negedge clk); #1;
        check_pred("R8 new value", 1'b1, 32'h300);

        // R9: decoy update fields with valid low change nothing
        upd_idx = IDX_A; upd_taken = 1'b0; upd_mispredict = 1'b1; upd_target = 32'hBAD0;
        repeat (4) @(negedge clk);
        fetch_pc = PC_A; #1;
        check_pred("R9 entry A", 1'b1, 32'h900);
        upd_idx = IDX_C;
        repeat (3) @(negedge clk);
        fetch_pc = PC_C; #1;
        check_pred("R9 entry C", 1'b1, 32'h300);

        // R4: strong taken absorbs one mismatch (A is 11 here)
        send_update(IDX_A, 1'b0, 1'b1, 32'h0);
        fetch_pc = PC_A; #1;
        check_pred("R4 strong hold dir", 1'b1, 32'h900);

        report();
    end

endmodule